// File: doc/BRIEF.md
# Scalar Bit-Manipulation Execution Unit

This unit performs one scalar bit-manipulation operation per cycle on 64-bit operands, or on 32-bit operands taken from the low half of each source. An issuing pipeline presents an operation select, a sub-operation code for the lowest-set-bit group, a width flag, two register sources, a third source holding the implicit data register for the widening multiply, and an 8-bit immediate. One clock later the unit returns a registered result (two halves for the multiply), a legality flag, and carry and zero flags.

The supported operations are and-not, bit-field extract, zero-high-bits, the three lowest-set-bit forms (reset, mask, isolate), register-count left, arithmetic-right and logical-right shifts, rotate-right by immediate, and an unsigned widening multiply. Field starts, lengths, indices and counts are clamped or masked according to the operand width. An operation counts as legal only when it arrived in the extended-prefix form with the vector-length bit clear; an illegal operation returns all-zero data and flags so the issuing logic can raise its own exception.

Top module: `bitx_unit`

## Requirements
- R1: `outValid` rises exactly one clock after a cycle with `inValid` high and is low one clock after a cycle with `inValid` low; all outputs are zero after reset.
- R2: `legal` is 1 only when `prefixOk`=1, `lenBit`=0 and `opSel` is 0 to 8; `opSel` 9 to 15 is illegal. An illegal operation returns `resLo`=0, `resHi`=0, `carryFlag`=0, `zeroFlag`=0.
- R3: `opSel`=0 (and-not) gives `srcA & ~srcB`; `zeroFlag` is 1 when that result is zero.
- R4: `opSel`=1 (extract) shifts `srcA` right by start `srcB[7:0]` (a start above size-1 yields zero), then keeps the low `len` bits, where `len`=`srcB[15:8]` clamped to size-1; `zeroFlag` reflects a zero result.
- R5: `opSel`=2 (zero-high) takes index `srcB[7:0]` clamped to size-1 and clears every bit of `srcA` at and above it; `carryFlag` is 1 when the unclamped index is at least size-1; `zeroFlag` reflects a zero result.
- R6: `opSel`=3 uses `subOp`: 1 resets the lowest set bit, 2 forms a mask up to and including the lowest set bit, 3 isolates the lowest set bit; any other `subOp` is illegal.
- R7: `opSel`=4/5/6 shift `srcA` left, right-arithmetic, right-logical by `srcB` masked to 6 bits (64-bit) or 5 bits (32-bit); in 32-bit mode the arithmetic shift fills with `srcA[31]`.
- R8: `opSel`=7 rotates `srcA` right within the operand width by `imm` masked to 6 or 5 bits.
- R9: `opSel`=8 multiplies `srcA` by `srcD` unsigned at operand width; `resLo` holds the low half and `resHi` the high half of the double-width product.
- R10: with `wideMode`=0 only the low 32 bits of each source are used and every result half has bits 63:32 zero; `resHi` is zero for every operation except `opSel`=8, `carryFlag` is zero except for `opSel`=2, and `zeroFlag` is zero except for `opSel` 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 4 | Operation select (R2 to R9) |
| subOp | input | 3 | Lowest-set-bit group sub-operation |
| wideMode | input | 1 | 1 for 64-bit operands, 0 for 32-bit |
| prefixOk | input | 1 | Operation arrived in the extended-prefix form |
| lenBit | input | 1 | Vector-length bit of the prefix |
| srcA | input | 64 | Primary operand |
| srcB | input | 64 | Second source: mask, control field or count |
| srcD | input | 64 | Implicit data register for the multiply |
| imm | input | 8 | Rotate immediate |
| outValid | output | 1 | Result registers hold a new result |
| legal | output | 1 | Operation was legal |
| resLo | output | 64 | Result, or low half of the product |
| resHi | output | 64 | High half of the product |
| carryFlag | output | 1 | Carry flag |
| zeroFlag | output | 1 | Zero flag |

## Verification
Every cycle the assertions check the one-cycle valid timing, the quiet outputs of an illegal or bad-form operation, the rejection of unknown lowest-set-bit codes, zero upper halves in 32-bit mode, that carry and the high half appear only for their own operations, that a set zero flag means a zero result, and that a zero-count left shift returns the operand. The exact arithmetic of each operation, the clamping of extract starts and lengths, the zero-high carry threshold, count and immediate masking and the product halves are shown only by the bench, which compares random and directed operations against its own bit-level model.

// File: rtl/bitx_pkg.sv
package bitx_pkg;

  localparam int DATA_W = 64;
  localparam int OP_W   = 4;
  localparam int SUB_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ANDN    = 4'd0,
    OP_EXTRACT = 4'd1,
    OP_ZHI     = 4'd2,
    OP_LSB     = 4'd3,
    OP_SHL     = 4'd4,
    OP_SAR     = 4'd5,
    OP_SHR     = 4'd6,
    OP_ROR     = 4'd7,
    OP_MULW    = 4'd8
  } bitop_e;

  localparam logic [SUB_W-1:0] LSB_RESET = 3'd1;
  localparam logic [SUB_W-1:0] LSB_MASK  = 3'd2;
  localparam logic [SUB_W-1:0] LSB_ISO   = 3'd3;

  // One-hot select strobes from control to datapath; all zero when illegal.
  typedef struct packed {
    logic selAndn;
    logic selExtract;
    logic selZhi;
    logic selLsbReset;
    logic selLsbMask;
    logic selLsbIso;
    logic selShl;
    logic selSar;
    logic selShr;
    logic selRor;
    logic selMul;
    logic wide;
    logic legal;
  } strobes_t;

endpackage

// File: rtl/bitx_ctrl.sv
module bitx_ctrl
  import bitx_pkg::*;
(
  input  logic [OP_W-1:0]  opSel,
  input  logic [SUB_W-1:0] subOp,
  input  logic             wideMode,
  input  logic             prefixOk,
  input  logic             lenBit,
  output strobes_t         strb
);

  logic formOk;
  logic opKnown;
  strobes_t raw;

  assign formOk = prefixOk & ~lenBit;

  always_comb begin
    raw = '0;
    opKnown = 1'b1;
    case (opSel)
      OP_ANDN:    raw.selAndn    = 1'b1;
      OP_EXTRACT: raw.selExtract = 1'b1;
      OP_ZHI:     raw.selZhi     = 1'b1;
      OP_LSB: begin
        case (subOp)
          LSB_RESET: raw.selLsbReset = 1'b1;
          LSB_MASK:  raw.selLsbMask  = 1'b1;
          LSB_ISO:   raw.selLsbIso   = 1'b1;
          default:   opKnown = 1'b0;
        endcase
      end
      OP_SHL:  raw.selShl = 1'b1;
      OP_SAR:  raw.selSar = 1'b1;
      OP_SHR:  raw.selShr = 1'b1;
      OP_ROR:  raw.selRor = 1'b1;
      OP_MULW: raw.selMul = 1'b1;
      default: opKnown = 1'b0;
    endcase
    raw.wide  = wideMode;
    raw.legal = formOk & opKnown;
  end

  // Strobes are gated so an illegal operation selects nothing.
  always_comb begin
    if (raw.legal) begin
      strb = raw;
    end else begin
      strb = '0;
      strb.wide = wideMode;
    end
  end

endmodule

// File: rtl/bitx_field_unit.sv
module bitx_field_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opN,
  input  logic [7:0]        ctlLow,
  input  logic [7:0]        ctlLen,
  input  logic [7:0]        sizeMax,
  output logic [DATA_W-1:0] extractRes,
  output logic [DATA_W-1:0] zhiRes,
  output logic              zhiCarry
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] shifted;
  logic [7:0]        lenClamp;
  logic [7:0]        idxClamp;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] keepMask;

  always_comb begin
    shifted    = (ctlLow > sizeMax) ? '0 : (opN >> ctlLow[CNT_W-1:0]);
    lenClamp   = (ctlLen > sizeMax) ? sizeMax : ctlLen;
    fieldMask  = (ONE << lenClamp[CNT_W-1:0]) - ONE;
    extractRes = shifted & fieldMask;
  end

  always_comb begin
    idxClamp = (ctlLow > sizeMax) ? sizeMax : ctlLow;
    keepMask = ~(ONES << idxClamp[CNT_W-1:0]);
    zhiRes   = opN & keepMask;
    zhiCarry = (ctlLow >= sizeMax);
  end

endmodule

// File: rtl/bitx_shift_unit.sv
module bitx_shift_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         srcA,
  input  logic [DATA_W-1:0]         opN,
  input  logic [$clog2(DATA_W)-1:0] regCount,
  input  logic [$clog2(DATA_W)-1:0] immCount,
  input  logic                      wide,
  input  logic [DATA_W-1:0]         sizeMask,
  output logic [DATA_W-1:0]         shlRes,
  output logic [DATA_W-1:0]         sarRes,
  output logic [DATA_W-1:0]         shrRes,
  output logic [DATA_W-1:0]         rorRes
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W);

  logic [CNT_W-1:0]    cntMask;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    rot;
  logic [DATA_W-1:0]   sarSrc;
  logic [DATA_W-1:0]   sarRaw;
  logic [2*DATA_W-1:0] dblWide;
  logic [DATA_W-1:0]   dblNarrow;

  assign cntMask = wide ? CNT_W'(DATA_W - 1) : CNT_W'(HALF_W - 1);
  assign cnt     = regCount & cntMask;
  assign rot     = immCount & cntMask;

  // Narrow arithmetic shift starts from a sign-extended operand.
  assign sarSrc  = wide ? srcA : {{HALF_W{srcA[HALF_W-1]}}, srcA[HALF_W-1:0]};
  assign sarRaw  = $signed(sarSrc) >>> cnt;

  assign shlRes  = (opN << cnt) & sizeMask;
  assign sarRes  = sarRaw & sizeMask;
  assign shrRes  = opN >> cnt;

  assign dblWide   = {srcA, srcA} >> rot;
  assign dblNarrow = {srcA[HALF_W-1:0], srcA[HALF_W-1:0]} >> rot;
  assign rorRes    = wide ? dblWide[DATA_W-1:0]
                          : {{HALF_W{1'b0}}, dblNarrow[HALF_W-1:0]};

endmodule

// File: rtl/bitx_datapath.sv
module bitx_datapath
  import bitx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcD,
  input  logic [7:0]        imm,
  output logic [DATA_W-1:0] nextLo,
  output logic [DATA_W-1:0] nextHi,
  output logic              nextCarry,
  output logic              nextZero
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0]   sizeMask;
  logic [7:0]          sizeMax;
  logic [DATA_W-1:0]   opN;
  logic [DATA_W-1:0]   ctlN;
  logic [DATA_W-1:0]   dN;

  logic [DATA_W-1:0]   andnRes;
  logic [DATA_W-1:0]   extractRes;
  logic [DATA_W-1:0]   zhiRes;
  logic                zhiCarry;
  logic [DATA_W-1:0]   minusOne;
  logic [DATA_W-1:0]   lsbResetRes;
  logic [DATA_W-1:0]   lsbMaskRes;
  logic [DATA_W-1:0]   lsbIsoRes;
  logic [DATA_W-1:0]   shlRes;
  logic [DATA_W-1:0]   sarRes;
  logic [DATA_W-1:0]   shrRes;
  logic [DATA_W-1:0]   rorRes;
  logic [2*DATA_W-1:0] product;
  logic [DATA_W-1:0]   mulLo;
  logic [DATA_W-1:0]   mulHi;
  logic                flagOp;

  assign sizeMask = strb.wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign sizeMax  = strb.wide ? 8'(DATA_W - 1) : 8'(HALF_W - 1);
  assign opN      = srcA & sizeMask;
  assign ctlN     = srcB & sizeMask;
  assign dN       = srcD & sizeMask;

  assign andnRes  = opN & ~ctlN;

  bitx_field_unit #(.DATA_W(DATA_W)) uField (
    .opN        (opN),
    .ctlLow     (srcB[7:0]),
    .ctlLen     (srcB[15:8]),
    .sizeMax    (sizeMax),
    .extractRes (extractRes),
    .zhiRes     (zhiRes),
    .zhiCarry   (zhiCarry)
  );

  assign minusOne    = opN - ONE;
  assign lsbResetRes = (opN & minusOne) & sizeMask;
  assign lsbMaskRes  = (opN ^ minusOne) & sizeMask;
  assign lsbIsoRes   = (opN & (~opN + ONE)) & sizeMask;

  bitx_shift_unit #(.DATA_W(DATA_W)) uShift (
    .srcA     (srcA),
    .opN      (opN),
    .regCount (srcB[CNT_W-1:0]),
    .immCount (imm[CNT_W-1:0]),
    .wide     (strb.wide),
    .sizeMask (sizeMask),
    .shlRes   (shlRes),
    .sarRes   (sarRes),
    .shrRes   (shrRes),
    .rorRes   (rorRes)
  );

  assign product = {{DATA_W{1'b0}}, opN} * {{DATA_W{1'b0}}, dN};

  generate
    if (DATA_W % 2 == 0) begin : gSplit
      assign mulLo = strb.wide ? product[DATA_W-1:0]
                               : {{HALF_W{1'b0}}, product[HALF_W-1:0]};
      assign mulHi = strb.wide ? product[2*DATA_W-1:DATA_W]
                               : {{HALF_W{1'b0}}, product[DATA_W-1:HALF_W]};
    end else begin : gNoSplit
      assign mulLo = product[DATA_W-1:0];
      assign mulHi = product[2*DATA_W-1:DATA_W];
    end
  endgenerate

  // AND-OR select over one-hot strobes.
  always_comb begin
    nextLo = ({DATA_W{strb.selAndn}}     & andnRes)
           | ({DATA_W{strb.selExtract}}  & extractRes)
           | ({DATA_W{strb.selZhi}}      & zhiRes)
           | ({DATA_W{strb.selLsbReset}} & lsbResetRes)
           | ({DATA_W{strb.selLsbMask}}  & lsbMaskRes)
           | ({DATA_W{strb.selLsbIso}}   & lsbIsoRes)
           | ({DATA_W{strb.selShl}}      & shlRes)
           | ({DATA_W{strb.selSar}}      & sarRes)
           | ({DATA_W{strb.selShr}}      & shrRes)
           | ({DATA_W{strb.selRor}}      & rorRes)
           | ({DATA_W{strb.selMul}}      & mulLo);
    nextHi = {DATA_W{strb.selMul}} & mulHi;
  end

  assign flagOp    = strb.selAndn | strb.selExtract | strb.selZhi;
  assign nextZero  = flagOp & (nextLo == '0);
  assign nextCarry = strb.selZhi & zhiCarry;

endmodule

// File: rtl/bitx_unit.sv
module bitx_unit
  import bitx_pkg::*;
#(
  parameter int DATA_W = bitx_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opSel,
  input  logic [2:0]        subOp,
  input  logic              wideMode,
  input  logic              prefixOk,
  input  logic              lenBit,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcD,
  input  logic [7:0]        imm,
  output logic              outValid,
  output logic              legal,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              carryFlag,
  output logic              zeroFlag
);

  strobes_t          strb;
  logic [DATA_W-1:0] nextLo;
  logic [DATA_W-1:0] nextHi;
  logic              nextCarry;
  logic              nextZero;

  bitx_ctrl uCtrl (
    .opSel    (opSel),
    .subOp    (subOp),
    .wideMode (wideMode),
    .prefixOk (prefixOk),
    .lenBit   (lenBit),
    .strb     (strb)
  );

  bitx_datapath #(.DATA_W(DATA_W)) uDp (
    .strb      (strb),
    .srcA      (srcA),
    .srcB      (srcB),
    .srcD      (srcD),
    .imm       (imm),
    .nextLo    (nextLo),
    .nextHi    (nextHi),
    .nextCarry (nextCarry),
    .nextZero  (nextZero)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      legal     <= 1'b0;
      resLo     <= '0;
      resHi     <= '0;
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        legal     <= strb.legal;
        resLo     <= nextLo;
        resHi     <= nextHi;
        carryFlag <= nextCarry;
        zeroFlag  <= nextZero;
      end
    end
  end

endmodule

// File: rtl/bitx_unit_check.sv
module bitx_unit_check #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opSel,
  input logic [2:0]        subOp,
  input logic              wideMode,
  input logic              prefixOk,
  input logic              lenBit,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic              outValid,
  input logic              legal,
  input logic [DATA_W-1:0] resLo,
  input logic [DATA_W-1:0] resHi,
  input logic              carryFlag,
  input logic              zeroFlag
);

  localparam int HALF_W = DATA_W / 2;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_bad_form_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (!prefixOk || lenBit) |=> !legal);

  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !legal |-> (resLo == '0) && (resHi == '0) && !carryFlag && !zeroFlag);

  assert_zero_means_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && zeroFlag |-> resLo == '0);

  assert_carry_only_zhi_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opSel != 4'd2) |=> !carryFlag);

  assert_bad_subop_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opSel == 4'd3) && ((subOp == 3'd0) || (subOp > 3'd3)) |=> !legal);

  assert_zero_count_shl_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && prefixOk && !lenBit && wideMode && (opSel == 4'd4) && (srcB[5:0] == 6'd0)
    |=> resLo == $past(srcA));

  assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !wideMode |=> (resLo[DATA_W-1:HALF_W] == '0) && (resHi[DATA_W-1:HALF_W] == '0));

  assert_hi_only_mul_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opSel != 4'd8) |=> resHi == '0);

endmodule

bind bitx_unit bitx_unit_check #(.DATA_W(DATA_W)) uCheck (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .subOp     (subOp),
  .wideMode  (wideMode),
  .prefixOk  (prefixOk),
  .lenBit    (lenBit),
  .srcA      (srcA),
  .srcB      (srcB),
  .outValid  (outValid),
  .legal     (legal),
  .resLo     (resLo),
  .resHi     (resHi),
  .carryFlag (carryFlag),
  .zeroFlag  (zeroFlag)
);

// File: tb/bitx_unit_test.sv
`timescale 1ns/1ps
module bitx_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [3:0]  opSel;
  logic [2:0]  subOp;
  logic        wideMode;
  logic        prefixOk;
  logic        lenBit;
  logic [63:0] srcA;
  logic [63:0] srcB;
  logic [63:0] srcD;
  logic [7:0]  imm;
  logic        outValid;
  logic        legal;
  logic [63:0] resLo;
  logic [63:0] resHi;
  logic        carryFlag;
  logic        zeroFlag;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bitx_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .subOp(subOp),
    .wideMode(wideMode), .prefixOk(prefixOk), .lenBit(lenBit), .srcA(srcA),
    .srcB(srcB), .srcD(srcD), .imm(imm), .outValid(outValid), .legal(legal),
    .resLo(resLo), .resHi(resHi), .carryFlag(carryFlag), .zeroFlag(zeroFlag)
  );

  // Bit-level reference: {legal, carry, zero, hi, lo}.
  function automatic logic [130:0] model(input logic [3:0] op, input logic [2:0] sub,
      input logic wide, input logic pfx, input logic lb, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input logic [7:0] im);
    int w;
    logic ok, cf, zf;
    logic [63:0] av, bv, dv, lo, hi;
    logic [127:0] prod;
    int start, len, idx, cnt, low;
    w  = wide ? 64 : 32;
    av = wide ? a : {32'b0, a[31:0]};
    bv = wide ? b : {32'b0, b[31:0]};
    dv = wide ? d : {32'b0, d[31:0]};
    ok = pfx && !lb && (op <= 4'd8) && (op != 4'd3 || (sub >= 3'd1 && sub <= 3'd3));
    lo = '0; hi = '0; cf = 1'b0; zf = 1'b0;
    if (!ok) return '0;
    low = -1;
    for (int i = w - 1; i >= 0; i--) if (av[i]) low = i;
    case (op)
      4'd0: lo = av & ~bv;
      4'd1: begin
        start = int'(b[7:0]);
        len   = int'(b[15:8]);
        if (len > w - 1) len = w - 1;
        for (int i = 0; i < w; i++)
          if (i < len && start + i < w) lo[i] = av[start + i];
      end
      4'd2: begin
        idx = int'(b[7:0]);
        cf  = (idx >= w - 1);
        if (idx > w - 1) idx = w - 1;
        for (int i = 0; i < w; i++) if (i < idx) lo[i] = av[i];
      end
      4'd3: begin
        if (sub == 3'd1) begin
          lo = av;
          if (low >= 0) lo[low] = 1'b0;
        end else if (sub == 3'd2) begin
          for (int i = 0; i < w; i++) lo[i] = (low < 0) || (i <= low);
        end else begin
          if (low >= 0) lo[low] = 1'b1;
        end
      end
      4'd4, 4'd5, 4'd6: begin
        cnt = int'(b[5:0]) & (w - 1);
        for (int i = 0; i < w; i++) begin
          if (op == 4'd4) lo[i] = (i >= cnt) ? av[i - cnt] : 1'b0;
          else if (i + cnt < w) lo[i] = av[i + cnt];
          else lo[i] = (op == 4'd5) ? av[w - 1] : 1'b0;
        end
      end
      4'd7: begin
        cnt = int'(im) & (w - 1);
        for (int i = 0; i < w; i++) lo[i] = av[(i + cnt) % w];
      end
      default: begin
        prod = {64'b0, av} * {64'b0, dv};
        if (wide) begin lo = prod[63:0]; hi = prod[127:64]; end
        else begin lo = {32'b0, prod[31:0]}; hi = {32'b0, prod[63:32]}; end
      end
    endcase
    if (op <= 4'd2) zf = (lo == 64'd0);
    return {ok, cf, zf, hi, lo};
  endfunction

  function automatic string tagOf(input logic [3:0] op, input logic ok);
    if (!ok) return "R2";
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [2:0] sub, input logic wide,
      input logic pfx, input logic lb, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] d, input logic [7:0] im, input string tag);
    logic [130:0] exp;
    logic [130:0] act;
    @(negedge clk);
    inValid = 1'b1; opSel = op; subOp = sub; wideMode = wide; prefixOk = pfx;
    lenBit = lb; srcA = a; srcB = b; srcD = d; imm = im;
    exp = model(op, sub, wide, pfx, lb, a, b, d, im);
    @(negedge clk);
    act = {legal, carryFlag, zeroFlag, resHi, resLo};
    total++;
    if (act !== exp || outValid !== 1'b1) begin
      bad++;
      $display("FAIL %s op=%0d wide=%0d act v=%0b l/c/z=%b hi=%h lo=%h exp l/c/z=%b hi=%h lo=%h",
               tag, op, wide, outValid, act[130:128], act[127:64], act[63:0],
               exp[130:128], exp[127:64], exp[63:0]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : mainFlow
    logic [3:0] op;
    logic [63:0] b;
    logic [130:0] e;
    void'($urandom(32'd20240517));
    rstN = 1'b0; inValid = 1'b0; opSel = '0; subOp = '0; wideMode = 1'b1;
    prefixOk = 1'b0; lenBit = 1'b0; srcA = '0; srcB = '0; srcD = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (outValid !== 1'b0 || legal !== 1'b0 || resLo !== '0 || resHi !== '0 ||
        carryFlag !== 1'b0 || zeroFlag !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset act v=%b l=%b lo=%h exp all zero", outValid, legal, resLo);
    end
    rstN = 1'b1;

    // Directed corner cases
    runOp(4'd0, 3'd0, 1'b1, 1'b0, 1'b0, 64'hFF, 64'h0F, 0, 0, "R2");          // no prefix form
    runOp(4'd0, 3'd0, 1'b1, 1'b1, 1'b1, 64'hFF, 64'h0F, 0, 0, "R2");          // length bit set
    runOp(4'd12, 3'd0, 1'b1, 1'b1, 1'b0, 64'hFF, 64'h0F, 0, 0, "R2");         // unknown op
    runOp(4'd0, 3'd0, 1'b1, 1'b1, 1'b0, 64'hF0F0, 64'hF0F0, 0, 0, "R3");      // zero result
    runOp(4'd1, 3'd0, 1'b1, 1'b1, 1'b0, '1, 64'h0804_46, 0, 0, "R4");         // start 70
    runOp(4'd1, 3'd0, 1'b1, 1'b1, 1'b0, '1, 64'hC804, 0, 0, "R4");            // len clamp
    runOp(4'd1, 3'd0, 1'b0, 1'b1, 1'b0, '1, 64'h2805, 0, 0, "R4");            // narrow len clamp
    runOp(4'd2, 3'd0, 1'b1, 1'b1, 1'b0, '1, 64'hFF, 0, 0, "R5");              // index 255
    runOp(4'd2, 3'd0, 1'b0, 1'b1, 1'b0, '1, 64'd30, 0, 0, "R5");              // narrow below
    runOp(4'd2, 3'd0, 1'b0, 1'b1, 1'b0, '1, 64'd31, 0, 0, "R5");              // narrow at limit
    runOp(4'd3, 3'd0, 1'b1, 1'b1, 1'b0, 64'h50, 0, 0, 0, "R6");               // bad sub-op
    runOp(4'd3, 3'd5, 1'b1, 1'b1, 1'b0, 64'h50, 0, 0, 0, "R6");               // bad sub-op
    runOp(4'd3, 3'd2, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, "R6"); // narrow zero
    runOp(4'd5, 3'd0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_8000_0010, 64'd36, 0, 0, "R7");
    runOp(4'd4, 3'd0, 1'b1, 1'b1, 1'b0, 64'h1, 64'd64, 0, 0, "R7");           // count wraps
    runOp(4'd6, 3'd0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, 0, "R7");
    runOp(4'd7, 3'd0, 1'b0, 1'b1, 1'b0, 64'h1234_5678_0000_0001, 0, 0, 8'd33, "R8");
    runOp(4'd7, 3'd0, 1'b1, 1'b1, 1'b0, 64'h1, 0, 0, 8'd65, "R8");
    runOp(4'd8, 3'd0, 1'b1, 1'b1, 1'b0, '1, 0, '1, 0, "R9");
    runOp(4'd8, 3'd0, 1'b0, 1'b1, 1'b0, '1, 0, '1, 0, "R9");
    runOp(4'd0, 3'd0, 1'b0, 1'b1, 1'b0, '1, 64'h0, 0, 0, "R10");              // narrow upper

    // R1: idle cycle drops outValid
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle act v=%b exp v=0", outValid);
    end

    // Constrained random mix
    for (int n = 0; n < 800; n++) begin
      op = 4'($urandom % 10);
      b  = {$urandom, $urandom};
      if ($urandom % 2 == 1) b[15:0] = {8'($urandom % 70), 8'($urandom % 70)};
      e = model(op, 3'($urandom % 5), 1'b1, 1'b1, 1'b0, 0, 0, 0, 0);
      runOp(op, 3'($urandom % 5), 1'($urandom % 2), ($urandom % 8) != 0,
            ($urandom % 8) == 0, {$urandom, $urandom}, b, {$urandom, $urandom},
            8'($urandom), (n % 7 == 0) ? "R10" : tagOf(op, e[130]));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule